// File: doc/BRIEF.md
# Inter-Processor Flag Mailbox Register

This block is a single-byte doorbell register shared by a host processor and a local communications processor. Each side first leaves a command or a response in a shared memory area. It then writes a code to this register to interrupt the other side. The block decodes writes from both sides, each arriving on its own synchronous write port with an address field and a data byte. From those writes it keeps two interrupt flags: one toward the local processor and one toward the host.

The host can also hold the local processor in reset. Any host write whose address field is zero starts a reset pulse of fixed length. While that pulse is high, the local processor is treated as not running and its writes are discarded. Both flags can be read back on a status port, so either processor can poll instead of taking the interrupt.

Codes: raise = 0x02, clear = 0x00. The default addresses are: host doorbell = 1; local doorbell = 1; local acknowledge = 2; host reset = 0.

Top module: `ipc_flag_mailbox`

## Requirements
- R1: A host write to the host doorbell address (default 1) with data 0x02 sets `irq_to_lp` in the cycle after the write.
- R2: A local write to the local doorbell address (default 1) with data 0x02 sets `irq_to_host` in the cycle after the write.
- R3: A local write to the local doorbell address with data 0x00 clears `irq_to_host` in the cycle after the write.
- R4: A local write to the local acknowledge address (default 2) with data 0x00 clears `irq_to_lp` in the cycle after the write.
- R5: A host write to address 0 raises `lp_reset` in the next cycle, whatever the data. `lp_reset` then stays high for exactly RST_CYCLES (default 8) cycles and drops by itself. A further address-0 host write during the pulse restarts the full count.
- R6: Local writes made while `lp_reset` is high have no effect on either interrupt flag.
- R7: Any other write leaves both interrupt flags unchanged. For the host this means any address other than 0 and the doorbell, or the doorbell with data other than 0x02. For the local side this means any address or code not listed in R2 to R4.
- R8: Host and local writes in the same cycle both take effect. If a host raise and a local acknowledge of `irq_to_lp` coincide, `irq_to_lp` ends set.
- R9: `status` bit 0 equals `irq_to_lp`, bit 1 equals `irq_to_host`, and bits 7:2 read zero.
- R10: While `rst_n` is low and after it is released, `irq_to_lp`, `irq_to_host`, `lp_reset` and `status` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host address field |
| host_wdata | input | 8 | Host write data |
| lp_wr_en | input | 1 | Local processor write strobe |
| lp_addr | input | ADDR_W | Local processor address field |
| lp_wdata | input | 8 | Local processor write data |
| irq_to_lp | output | 1 | Interrupt toward the local processor |
| irq_to_host | output | 1 | Interrupt toward the host |
| lp_reset | output | 1 | Reset pulse toward the local processor |
| status | output | 8 | Flag readback: bit 1 host interrupt, bit 0 local interrupt |

## Verification
The two functions that can fall in the same cycle are a host raise of `irq_to_lp` and a local acknowledge clearing that same flag. A related case is a host reset request arriving alongside a local write. The bench drives both ports in one cycle with the flag preset to each value. It expects the raise to win, and expects a local write that lands with the reset request to still take effect. Exhaustive sweeps over every address and data byte on each port check all other codes against arithmetic expectations, and the reset pulse is timed by counting its cycles.

// File: rtl/ipc_flag_pkg.sv
package ipc_flag_pkg;

  localparam logic [7:0] CODE_RAISE = 8'h02;
  localparam logic [7:0] CODE_CLEAR = 8'h00;

  localparam int NUM_FLAGS  = 2;
  localparam int FLAG_LP    = 0;
  localparam int FLAG_HOST  = 1;
  localparam int STATUS_W   = 8;

endpackage

// File: rtl/ipc_host_decode.sv
module ipc_host_decode #(
  parameter int ADDR_W    = 4,
  parameter int FLAG_ADDR = 1
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              set_lp,
  output logic              start_rst
);
  import ipc_flag_pkg::*;

  localparam logic [ADDR_W-1:0] DOORBELL_A = ADDR_W'(FLAG_ADDR);
  localparam logic [ADDR_W-1:0] RESET_A    = '0;

  always_comb begin
    start_rst = wr_en && (addr == RESET_A);
    set_lp    = wr_en && (addr == DOORBELL_A) && (wdata == CODE_RAISE);
  end
endmodule

// File: rtl/ipc_lp_decode.sv
module ipc_lp_decode #(
  parameter int ADDR_W    = 4,
  parameter int FLAG_ADDR = 1,
  parameter int ACK_ADDR  = 2
) (
  input  logic              wr_en,
  input  logic              blocked,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              set_host,
  output logic              clr_host,
  output logic              clr_lp
);
  import ipc_flag_pkg::*;

  localparam logic [ADDR_W-1:0] DOORBELL_A = ADDR_W'(FLAG_ADDR);
  localparam logic [ADDR_W-1:0] ACK_A      = ADDR_W'(ACK_ADDR);

  logic live;

  always_comb begin
    live     = wr_en && !blocked;
    set_host = live && (addr == DOORBELL_A) && (wdata == CODE_RAISE);
    clr_host = live && (addr == DOORBELL_A) && (wdata == CODE_CLEAR);
    clr_lp   = live && (addr == ACK_A)      && (wdata == CODE_CLEAR);
  end
endmodule

// File: rtl/ipc_irq_flag.sv
module ipc_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = set_i || clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ipc_reset_pulse.sv
module ipc_reset_pulse #(
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic pulse_o
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(RST_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start_i || (cnt_q != '0);
    if (start_i) cnt_d = LOAD_V;
    else         cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/ipc_flag_mailbox.sv
module ipc_flag_mailbox #(
  parameter int ADDR_W         = 4,
  parameter int HOST_FLAG_ADDR = 1,
  parameter int LP_FLAG_ADDR   = 1,
  parameter int LP_ACK_ADDR    = 2,
  parameter int RST_CYCLES     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              lp_wr_en,
  input  logic [ADDR_W-1:0] lp_addr,
  input  logic [7:0]        lp_wdata,
  output logic              irq_to_lp,
  output logic              irq_to_host,
  output logic              lp_reset,
  output logic [7:0]        status
);
  import ipc_flag_pkg::*;

  logic h_set_lp, h_start_rst;
  logic l_set_host, l_clr_host, l_clr_lp;
  logic [NUM_FLAGS-1:0] set_v, clr_v, flag_v;

  ipc_host_decode #(.ADDR_W(ADDR_W), .FLAG_ADDR(HOST_FLAG_ADDR)) u_hdec (
    .wr_en(host_wr_en), .addr(host_addr), .wdata(host_wdata),
    .set_lp(h_set_lp), .start_rst(h_start_rst)
  );

  ipc_lp_decode #(.ADDR_W(ADDR_W), .FLAG_ADDR(LP_FLAG_ADDR), .ACK_ADDR(LP_ACK_ADDR)) u_ldec (
    .wr_en(lp_wr_en), .blocked(lp_reset), .addr(lp_addr), .wdata(lp_wdata),
    .set_host(l_set_host), .clr_host(l_clr_host), .clr_lp(l_clr_lp)
  );

  ipc_reset_pulse #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .start_i(h_start_rst), .pulse_o(lp_reset)
  );

  always_comb begin
    set_v[FLAG_LP]   = h_set_lp;
    clr_v[FLAG_LP]   = l_clr_lp;
    set_v[FLAG_HOST] = l_set_host;
    clr_v[FLAG_HOST] = l_clr_host;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    ipc_irq_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(set_v[g]), .clr_i(clr_v[g]), .flag_o(flag_v[g])
    );
  end

  assign irq_to_lp   = flag_v[FLAG_LP];
  assign irq_to_host = flag_v[FLAG_HOST];
  assign status      = {{(STATUS_W-NUM_FLAGS){1'b0}}, flag_v};
endmodule

// File: rtl/ipc_flag_mailbox_chk.sv
module ipc_flag_mailbox_chk #(
  parameter int ADDR_W         = 4,
  parameter int HOST_FLAG_ADDR = 1,
  parameter int LP_FLAG_ADDR   = 1,
  parameter int LP_ACK_ADDR    = 2,
  parameter int RST_CYCLES     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr_en,
  input logic [ADDR_W-1:0] host_addr,
  input logic [7:0]        host_wdata,
  input logic              lp_wr_en,
  input logic [ADDR_W-1:0] lp_addr,
  input logic [7:0]        lp_wdata,
  input logic              irq_to_lp,
  input logic              irq_to_host,
  input logic              lp_reset,
  input logic [7:0]        status
);
  localparam logic [ADDR_W-1:0] HF_A = ADDR_W'(HOST_FLAG_ADDR);
  localparam logic [ADDR_W-1:0] LF_A = ADDR_W'(LP_FLAG_ADDR);
  localparam logic [ADDR_W-1:0] LA_A = ADDR_W'(LP_ACK_ADDR);
  localparam int CW = $clog2(RST_CYCLES + 2);
  localparam logic [CW-1:0] LIM = CW'(RST_CYCLES);

  logic          trig, seen;
  logic [CW-1:0] since;

  assign trig = host_wr_en && (host_addr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen  <= 1'b0;
      since <= '0;
    end else if (trig) begin
      seen  <= 1'b1;
      since <= CW'(1);
    end else if (seen && since <= LIM) begin
      since <= since + 1'b1;
    end
  end

  p_raise_lp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_en && host_addr == HF_A && host_wdata == 8'h02 |=> irq_to_lp);

  p_raise_host_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_reset && lp_wr_en && lp_addr == LF_A && lp_wdata == 8'h02 |=> irq_to_host);

  p_clear_host_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_reset && lp_wr_en && lp_addr == LF_A && lp_wdata == 8'h00 |=> !irq_to_host);

  p_ack_lp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_reset && lp_wr_en && lp_addr == LA_A && lp_wdata == 8'h00
    && !(host_wr_en && host_addr == HF_A && host_wdata == 8'h02) |=> !irq_to_lp);

  p_pulse_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lp_reset == (seen && since <= LIM));

  p_lp_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lp_reset |=> $stable(irq_to_host));

  p_host_other_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_wr_en && !(host_wr_en && host_addr == HF_A && host_wdata == 8'h02)
    |=> $stable(irq_to_lp) && $stable(irq_to_host));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_en && host_addr == HF_A && host_wdata == 8'h02
    && lp_wr_en && lp_addr == LA_A && lp_wdata == 8'h00 |=> irq_to_lp);

  p_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:2] == 6'd0 && status[0] == irq_to_lp && status[1] == irq_to_host);
endmodule

bind ipc_flag_mailbox ipc_flag_mailbox_chk #(
  .ADDR_W(ADDR_W), .HOST_FLAG_ADDR(HOST_FLAG_ADDR), .LP_FLAG_ADDR(LP_FLAG_ADDR),
  .LP_ACK_ADDR(LP_ACK_ADDR), .RST_CYCLES(RST_CYCLES)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .host_wr_en(host_wr_en), .host_addr(host_addr), .host_wdata(host_wdata),
  .lp_wr_en(lp_wr_en), .lp_addr(lp_addr), .lp_wdata(lp_wdata),
  .irq_to_lp(irq_to_lp), .irq_to_host(irq_to_host), .lp_reset(lp_reset),
  .status(status)
);

// File: tb/ipc_flag_mailbox_tb_top.sv
`timescale 1ns/1ps
module ipc_flag_mailbox_tb_top;
  localparam int AW = 4;
  localparam int PULSE = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_wr_en, lp_wr_en;
  logic [AW-1:0] host_addr, lp_addr;
  logic [7:0]    host_wdata, lp_wdata;
  logic          irq_to_lp, irq_to_host, lp_reset;
  logic [7:0]    status;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ipc_flag_mailbox #(.ADDR_W(AW), .RST_CYCLES(PULSE)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_addr(host_addr), .host_wdata(host_wdata),
    .lp_wr_en(lp_wr_en), .lp_addr(lp_addr), .lp_wdata(lp_wdata),
    .irq_to_lp(irq_to_lp), .irq_to_host(irq_to_host), .lp_reset(lp_reset),
    .status(status)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag, input int e_lp, input int e_host);
    check({tag, " irq_to_lp"}, int'(irq_to_lp), e_lp);
    check({tag, " irq_to_host"}, int'(irq_to_host), e_host);
    check({"R9 status after ", tag}, int'(status), e_host * 2 + e_lp);
  endtask

  task automatic cyc(input logic he, input logic [AW-1:0] ha, input logic [7:0] hd,
                     input logic le, input logic [AW-1:0] la, input logic [7:0] ld);
    host_wr_en = he; host_addr = ha; host_wdata = hd;
    lp_wr_en = le; lp_addr = la; lp_wdata = ld;
    @(posedge clk);
    @(negedge clk);
    host_wr_en = 1'b0;
    lp_wr_en = 1'b0;
  endtask

  task automatic count_high(output int n);
    n = 0;
    while (lp_reset && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic set_flags(input bit pl, input bit ph);
    cyc(pl, 4'd1, 8'h02, 1'b1, 4'd1, ph ? 8'h02 : 8'h00);
    if (!pl) cyc(1'b0, 4'd0, 8'h00, 1'b1, 4'd2, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=completed");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0;
    host_wr_en = 1'b0; host_addr = '0; host_wdata = '0;
    lp_wr_en = 1'b0; lp_addr = '0; lp_wdata = '0;
    repeat (3) @(negedge clk);
    check_state("R10 in reset", 0, 0);
    check("R10 lp_reset in reset", int'(lp_reset), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R10 after release", 0, 0);
    check("R10 lp_reset after release", int'(lp_reset), 0);

    // R1 R5 R7: every host address and data byte
    for (int a = 0; a < 16; a++) begin
      for (int d = 0; d < 256; d++) begin
        bit pl, ph;
        int e_lp;
        pl = ((a + d) % 2) == 1;
        ph = !pl;
        set_flags(pl, ph);
        cyc(1'b1, AW'(a), 8'(d), 1'b0, 4'd0, 8'h00);
        e_lp = (pl || (a == 1 && d == 2)) ? 1 : 0;
        check_state("R1/R7 host sweep", e_lp, int'(ph));
        check("R5 host sweep lp_reset", int'(lp_reset), (a == 0) ? 1 : 0);
        if (a == 0) begin
          count_high(n);
          check("R5 pulse length", n, PULSE);
        end
      end
    end

    // R2 R3 R4 R7: every local address and data byte
    for (int a = 0; a < 16; a++) begin
      for (int d = 0; d < 256; d++) begin
        bit pl, ph;
        int e_lp, e_host;
        ph = ((a ^ d) & 1) == 1;
        pl = !ph;
        set_flags(pl, ph);
        cyc(1'b0, 4'd0, 8'h00, 1'b1, AW'(a), 8'(d));
        e_host = (a == 1 && d == 2) ? 1 : (a == 1 && d == 0) ? 0 : int'(ph);
        e_lp   = (a == 2 && d == 0) ? 0 : int'(pl);
        check_state("R2/R3/R4/R7 lp sweep", e_lp, e_host);
      end
    end

    // R5 restart during pulse
    cyc(1'b1, 4'd0, 8'h5A, 1'b0, 4'd0, 8'h00);
    repeat (3) @(negedge clk);
    check("R5 still high mid pulse", int'(lp_reset), 1);
    cyc(1'b1, 4'd0, 8'h00, 1'b0, 4'd0, 8'h00);
    count_high(n);
    check("R5 restarted pulse length", n, PULSE);

    // R6 local writes discarded during reset
    set_flags(1'b1, 1'b0);
    cyc(1'b1, 4'd0, 8'h00, 1'b0, 4'd0, 8'h00);
    cyc(1'b0, 4'd0, 8'h00, 1'b1, 4'd2, 8'h00);
    check_state("R6 ack ignored in reset", 1, 0);
    cyc(1'b0, 4'd0, 8'h00, 1'b1, 4'd1, 8'h02);
    check_state("R6 raise ignored in reset", 1, 0);
    count_high(n);
    cyc(1'b0, 4'd0, 8'h00, 1'b1, 4'd1, 8'h02);
    check_state("R6 raise honoured after reset", 1, 1);

    // R8 same-cycle writes
    set_flags(1'b1, 1'b1);
    cyc(1'b1, 4'd1, 8'h02, 1'b1, 4'd2, 8'h00);
    check_state("R8 raise beats ack (preset 1)", 1, 1);
    set_flags(1'b0, 1'b1);
    cyc(1'b1, 4'd1, 8'h02, 1'b1, 4'd2, 8'h00);
    check_state("R8 raise beats ack (preset 0)", 1, 1);
    set_flags(1'b0, 1'b0);
    cyc(1'b1, 4'd1, 8'h02, 1'b1, 4'd1, 8'h02);
    check_state("R8 both raises", 1, 1);
    set_flags(1'b0, 1'b1);
    cyc(1'b1, 4'd0, 8'h00, 1'b1, 4'd1, 8'h00);
    check_state("R8 clear with reset request", 0, 0);
    check("R8 reset with local write", int'(lp_reset), 1);
    count_high(n);
    check("R5 pulse after shared cycle", n, PULSE);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule